// File: doc/BRIEF.md
# Multi-Error ECC Correction Applier

This block sits behind a four-error sector decoder and turns its results into repairs of a 512-byte sector buffer. A pulse on `start` begins one sector. If every syndrome word is zero, the sector is already clean. The block then reports zero repairs and never touches the decoder. Otherwise it pulses `calc_start` to launch the decoder's error-location pass.

The decoder's state field can read "complete" for a short time after launch even though no work has been done yet. The block therefore ignores the decoder until its state climbs to 4 or above, or until a bounded settle window of `TIMEOUT_CYC` cycles runs out. Only then does it poll the state. It then ends cleanly, reports a failure, or takes the error count and walks the errors one per cycle.

Each error location is a reversed 10-bit index that is offset by 7, so the byte offset is 519 minus the index. Offsets outside the data area are dropped without counting them. Every repair is a single-cycle read, XOR and write on the buffer port. A one-cycle `done` pulse carries the final repair count or the failure flag.

Top module: `ecc4_fixup`

## Requirements
- R1: After reset, `done`, `fail`, `calc_start` and `buf_wr_en` are low and `fixed_cnt` is 0.
- R2: When `start` is sampled and all bits of `syn_words` are zero, `done` is high in the next cycle with `fixed_cnt`=0 and `fail`=0, and `calc_start` never rises for that sector.
- R3: When `start` is sampled with any syndrome bit set, `calc_start` is high for exactly one cycle, in the cycle after the sampling edge.
- R4: After `calc_start`, the decoder state (`dec_status[11:8]`) is disregarded until it reads 4 or more, or until `TIMEOUT_CYC` cycles have passed. A state of 3 present from launch therefore delays `done` by at least `TIMEOUT_CYC` cycles. A state of 4 or more ends the wait early.
- R5: While polling, state 0 ends the sector with `fixed_cnt`=0 and `fail`=0. State 1 ends it with `fail`=1 and `fixed_cnt`=0. States 4 to 15 keep the block waiting.
- R6: On state 2 or 3, the error count is 1 plus `dec_status[17:16]`. Error k (k = 0 to 3) takes its location from `loc_pair0` when k<2 and from `loc_pair1` otherwise, and its value from `mag_pair0` or `mag_pair1` in the same way. The upper 16-bit half (bits 25:16 for the location, bits 23:16 for the value) is used for odd k, and the lower half (bits 9:0 and 7:0) for even k. Errors beyond the count are not used.
- R7: For each used error, the byte offset is 519 minus the 10-bit location. In one cycle, `buf_wr_en` is high, `buf_addr` is the offset and `buf_wdata` is `buf_rdata` XOR the 8-bit value.
- R8: An error whose offset is 512 or more, or negative (location below 8 or above 519), causes no buffer write and is not counted.
- R9: `done` is a single-cycle pulse. With it, `fixed_cnt` equals the number of buffer writes made for that sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin processing one sector |
| syn_words | input | 4*SYN_W | Four syndrome words, packed |
| calc_start | output | 1 | One-cycle launch of the decoder location pass |
| dec_status | input | STAT_W | Decoder status: state at 11:8, count-1 at 17:16 |
| loc_pair0 | input | 2*HALF_W | Locations of errors 0 (low half) and 1 (high half) |
| loc_pair1 | input | 2*HALF_W | Locations of errors 2 (low half) and 3 (high half) |
| mag_pair0 | input | 2*HALF_W | Values of errors 0 and 1 |
| mag_pair1 | input | 2*HALF_W | Values of errors 2 and 3 |
| buf_addr | output | OFS_W | Sector buffer byte address |
| buf_rdata | input | 8 | Combinational read data at `buf_addr` |
| buf_wdata | output | 8 | Repaired byte |
| buf_wr_en | output | 1 | Buffer write strobe |
| done | output | 1 | End-of-sector pulse |
| fail | output | 1 | Decoder reported five or more errors |
| fixed_cnt | output | 3 | Bytes repaired for the sector |

## Verification
Two pairs of functions can collide in time. The first pair is the settle window and the decoder's state change. The bench provokes this by holding a false "complete" state from launch, and separately by raising a busy state and then ready a few cycles after launch. It judges both by the launch-to-done latency against the window length.

The second pair is the final buffer write and the `done` pulse. The per-clock reference model expects each write at its exact offset in queue order, and expects `done` only in the cycle after the last one, with the count of writes actually seen.

// File: rtl/ecc4fx_pkg.sv
package ecc4fx_pkg;

   typedef enum logic [2:0] {
      FX_IDLE,
      FX_LAUNCH,
      FX_SETTLE,
      FX_POLL,
      FX_APPLY
   } fx_state_t;

   typedef enum logic [1:0] {
      DEC_CLEAN,
      DEC_FAIL,
      DEC_READY,
      DEC_BUSY
   } dec_class_t;

   localparam int DEC_BUSY_MIN = 4;

   function automatic dec_class_t classify(input logic [3:0] st);
      if (st == 4'd0)      return DEC_CLEAN;
      else if (st == 4'd1) return DEC_FAIL;
      else if (st < 4'(DEC_BUSY_MIN)) return DEC_READY;
      else                 return DEC_BUSY;
   endfunction

endpackage

// File: rtl/ecc4fx_settle.sv
module ecc4fx_settle #(
   parameter int TIMEOUT_CYC = 5000,
   parameter int ST_W        = 4,
   parameter int BUSY_MIN    = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  logic [ST_W-1:0] dec_state,
   output logic            ready
);
   localparam int CW = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("TIMEOUT_CYC must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!active)        cnt_q <= '0;
      else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
   end

   assign ready = active && ((dec_state >= ST_W'(BUSY_MIN)) || (cnt_q == LAST));

   // R4: the settle counter never runs past the window
   p_settle_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> cnt_q <= LAST);

endmodule

// File: rtl/ecc4fx_pick.sv
module ecc4fx_pick #(
   parameter int SECTOR_BYTES = 512,
   parameter int ADDR_OFS     = 7,
   parameter int ADDR_W       = 10,
   parameter int VAL_W        = 8,
   parameter int HALF_W       = 16,
   localparam int OFS_W       = $clog2(SECTOR_BYTES)
) (
   input  logic [2*HALF_W-1:0] loc_pair0,
   input  logic [2*HALF_W-1:0] loc_pair1,
   input  logic [2*HALF_W-1:0] mag_pair0,
   input  logic [2*HALF_W-1:0] mag_pair1,
   input  logic [1:0]          idx,
   output logic [OFS_W-1:0]    offset,
   output logic [VAL_W-1:0]    value,
   output logic                hit
);
   localparam int TOP = SECTOR_BYTES + ADDR_OFS;

   generate
      if (TOP >= (1 << ADDR_W)) begin : g_bad_top
         $error("SECTOR_BYTES + ADDR_OFS must fit in ADDR_W bits");
      end
      if (ADDR_W > HALF_W || VAL_W > HALF_W) begin : g_bad_half
         $error("fields must fit in a register half");
      end
      if ((1 << OFS_W) != SECTOR_BYTES) begin : g_bad_sector
         $error("SECTOR_BYTES must be a power of two");
      end
   endgenerate

   logic [2*HALF_W-1:0] locs [2];
   logic [2*HALF_W-1:0] mags [2];
   logic [ADDR_W-1:0]   slot_loc [4];
   logic [VAL_W-1:0]    slot_mag [4];

   assign locs[0] = loc_pair0;
   assign locs[1] = loc_pair1;
   assign mags[0] = mag_pair0;
   assign mags[1] = mag_pair1;

   for (genvar k = 0; k < 4; k++) begin : g_slot
      assign slot_loc[k] = locs[k/2][(k%2)*HALF_W +: ADDR_W];
      assign slot_mag[k] = mags[k/2][(k%2)*HALF_W +: VAL_W];
   end

   logic [ADDR_W-1:0] loc_sel;
   logic [ADDR_W:0]   diff;

   assign loc_sel = slot_loc[idx];
   assign value   = slot_mag[idx];
   assign diff    = (ADDR_W+1)'(TOP) - {1'b0, loc_sel};
   assign hit     = (loc_sel > ADDR_W'(ADDR_OFS)) && (loc_sel <= ADDR_W'(TOP));
   assign offset  = diff[OFS_W-1:0];

endmodule

// File: rtl/ecc4_fixup.sv
module ecc4_fixup
   import ecc4fx_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int ADDR_OFS     = 7,
   parameter int ADDR_W       = 10,
   parameter int HALF_W       = 16,
   parameter int SYN_W        = 32,
   parameter int STAT_W       = 32,
   parameter int ST_LSB       = 8,
   parameter int NUM_LSB      = 16,
   parameter int TIMEOUT_CYC  = 5000,
   localparam int OFS_W       = $clog2(SECTOR_BYTES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [4*SYN_W-1:0]  syn_words,
   output logic                calc_start,
   input  logic [STAT_W-1:0]   dec_status,
   input  logic [2*HALF_W-1:0] loc_pair0,
   input  logic [2*HALF_W-1:0] loc_pair1,
   input  logic [2*HALF_W-1:0] mag_pair0,
   input  logic [2*HALF_W-1:0] mag_pair1,
   output logic [OFS_W-1:0]    buf_addr,
   input  logic [7:0]          buf_rdata,
   output logic [7:0]          buf_wdata,
   output logic                buf_wr_en,
   output logic                done,
   output logic                fail,
   output logic [2:0]          fixed_cnt
);
   generate
      if (ST_LSB + 4 > STAT_W || NUM_LSB + 2 > STAT_W) begin : g_bad_status
         $error("status fields exceed STAT_W");
      end
   endgenerate

   fx_state_t  state_q;
   dec_class_t cls;
   logic [3:0] dec_state;
   logic [1:0] last_idx_q, idx_q;
   logic       settled, hit;
   logic [7:0] err_val;

   assign dec_state = dec_status[ST_LSB +: 4];
   assign cls       = classify(dec_state);

   ecc4fx_settle #(
      .TIMEOUT_CYC (TIMEOUT_CYC),
      .ST_W        (4),
      .BUSY_MIN    (DEC_BUSY_MIN)
   ) u_settle (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (state_q == FX_SETTLE),
      .dec_state (dec_state),
      .ready     (settled)
   );

   ecc4fx_pick #(
      .SECTOR_BYTES (SECTOR_BYTES),
      .ADDR_OFS     (ADDR_OFS),
      .ADDR_W       (ADDR_W),
      .VAL_W        (8),
      .HALF_W       (HALF_W)
   ) u_pick (
      .loc_pair0 (loc_pair0),
      .loc_pair1 (loc_pair1),
      .mag_pair0 (mag_pair0),
      .mag_pair1 (mag_pair1),
      .idx       (idx_q),
      .offset    (buf_addr),
      .value     (err_val),
      .hit       (hit)
   );

   assign calc_start = (state_q == FX_LAUNCH);
   assign buf_wr_en  = (state_q == FX_APPLY) && hit;
   assign buf_wdata  = buf_rdata ^ err_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= FX_IDLE;
         done       <= 1'b0;
         fail       <= 1'b0;
         fixed_cnt  <= '0;
         idx_q      <= '0;
         last_idx_q <= '0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            FX_IDLE: if (start) begin
               fixed_cnt <= '0;
               fail      <= 1'b0;
               if (~|syn_words) done    <= 1'b1;
               else             state_q <= FX_LAUNCH;
            end
            FX_LAUNCH: state_q <= FX_SETTLE;
            FX_SETTLE: if (settled) state_q <= FX_POLL;
            FX_POLL: unique case (cls)
               DEC_CLEAN: begin done <= 1'b1; state_q <= FX_IDLE; end
               DEC_FAIL:  begin done <= 1'b1; fail <= 1'b1; state_q <= FX_IDLE; end
               DEC_READY: begin
                  last_idx_q <= dec_status[NUM_LSB +: 2];
                  idx_q      <= '0;
                  state_q    <= FX_APPLY;
               end
               default: ;
            endcase
            FX_APPLY: begin
               if (hit) fixed_cnt <= fixed_cnt + 1'b1;
               if (idx_q == last_idx_q) begin
                  done    <= 1'b1;
                  state_q <= FX_IDLE;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: state_q <= FX_IDLE;
         endcase
      end
   end

   // R9: done lasts one cycle
   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R3: launch pulse is one cycle and follows a start
   p_calc_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      calc_start |=> !calc_start);
   p_calc_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      calc_start |-> $past(start));
   // R5: a failure carries no repairs
   p_fail_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> fixed_cnt == 3'd0);
   // R7: buffer writes never overlap the launch or the done pulse
   p_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr_en |-> !done && !calc_start);
   // R9: the count never exceeds four repairs
   p_cnt_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fixed_cnt <= 3'd4);

endmodule

// File: tb/sim_ecc4_fixup.sv
module sim_ecc4_fixup;
   localparam int TMO = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [127:0] syn_words = '0;
   logic        calc_start;
   logic [31:0] dec_status = '0;
   logic [31:0] loc_pair0 = '0, loc_pair1 = '0, mag_pair0 = '0, mag_pair1 = '0;
   logic [8:0]  buf_addr;
   logic [7:0]  buf_rdata, buf_wdata;
   logic        buf_wr_en, done, fail;
   logic [2:0]  fixed_cnt;

   logic [7:0] mem    [512];
   logic [7:0] expmem [512];
   int q_addr[$];
   int q_data[$];
   int errs = 0, checks = 0, writes = 0;
   bit calc_seen = 0;
   longint cyc = 0;

   always #10 clk = ~clk;   // 50 MHz

   ecc4_fixup #(.TIMEOUT_CYC(TMO)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .syn_words(syn_words),
      .calc_start(calc_start), .dec_status(dec_status),
      .loc_pair0(loc_pair0), .loc_pair1(loc_pair1),
      .mag_pair0(mag_pair0), .mag_pair1(mag_pair1),
      .buf_addr(buf_addr), .buf_rdata(buf_rdata), .buf_wdata(buf_wdata),
      .buf_wr_en(buf_wr_en), .done(done), .fail(fail), .fixed_cnt(fixed_cnt));

   assign buf_rdata = mem[buf_addr];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // per-clock reference comparison of buffer writes
   always @(negedge clk) begin
      cyc++;
      if (calc_start) calc_seen = 1;
      if (buf_wr_en) begin
         writes++;
         if (q_addr.size() == 0) begin
            chk(0, "R8 unexpected write", buf_addr, -1);
         end else begin
            int ea, ed;
            ea = q_addr.pop_front();
            ed = q_data.pop_front();
            chk(buf_addr == ea, "R7 write address", buf_addr, ea);
            chk(buf_wdata == ed[7:0], "R7 write data", buf_wdata, ed);
         end
         mem[buf_addr] = buf_wdata;
      end
      if (cyc > 20000) begin
         errs++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   // behavioural model: returns expected repair count, fills write queue
   function automatic int model(input logic [31:0] st);
      int n, cnt;
      n = 1 + st[17:16];
      cnt = 0;
      for (int k = 0; k < n; k++) begin
         logic [31:0] lw, mw;
         int a, off, v;
         lw = (k < 2) ? loc_pair0 : loc_pair1;
         mw = (k < 2) ? mag_pair0 : mag_pair1;
         a = (k % 2) ? lw[25:16] : lw[9:0];
         v = (k % 2) ? mw[23:16] : mw[7:0];
         off = 519 - a;
         if (off >= 0 && off < 512) begin
            q_addr.push_back(off);
            q_data.push_back(expmem[off] ^ v[7:0]);
            expmem[off] = expmem[off] ^ v[7:0];
            cnt++;
         end
      end
      return cnt;
   endfunction

   // run a sector: pre status at launch, final status after dly cycles
   task automatic run(input string tag, input logic [31:0] pre, input logic [31:0] fin,
                      input int dly, input int exp_cnt, input bit exp_fail,
                      output int lat);
      int t;
      bit got;
      calc_seen = 0;
      writes = 0;
      dec_status = pre;
      @(negedge clk) start = 1;
      @(negedge clk) start = 0;
      chk(calc_start == 1, {tag, " R3 launch"}, calc_start, 1);
      lat = 0; got = 0;
      for (t = 0; t < 400 && !got; t++) begin
         @(negedge clk);
         lat++;
         if (lat == dly) dec_status = fin;
         chk(calc_start == 0, {tag, " R3 single launch"}, calc_start, 0);
         if (done) got = 1;
      end
      chk(got, {tag, " R9 done seen"}, got, 1);
      chk(fixed_cnt == exp_cnt, {tag, " R9 count"}, fixed_cnt, exp_cnt);
      chk(writes == exp_cnt, {tag, " R8 write total"}, writes, exp_cnt);
      chk(fail == exp_fail, {tag, " R5 fail flag"}, fail, exp_fail);
      @(negedge clk);
      chk(done == 0, {tag, " R9 one-cycle done"}, done, 0);
   endtask

   initial begin
      int lat, ec, mism;
      for (int i = 0; i < 512; i++) begin
         mem[i] = 8'((i * 7) ^ 8'h3C);
         expmem[i] = mem[i];
      end
      repeat (3) @(negedge clk);
      chk(done == 0 && fail == 0 && fixed_cnt == 0, "R1 reset outputs", {done, fail, fixed_cnt}, 0);
      chk(calc_start == 0 && buf_wr_en == 0, "R1 reset strobes", {calc_start, buf_wr_en}, 0);
      rst_n = 1;
      @(negedge clk);

      // R2: clean syndrome, decoder never launched
      syn_words = '0;
      dec_status = 32'h0000_0300;
      calc_seen = 0;
      @(negedge clk) start = 1;
      @(negedge clk) start = 0;
      chk(done == 1, "R2 immediate done", done, 1);
      chk(fixed_cnt == 0 && fail == 0, "R2 zero count", fixed_cnt, 0);
      repeat (3) @(negedge clk);
      chk(calc_seen == 0, "R2 no launch", calc_seen, 0);

      syn_words = 128'h1 << 70;

      // R6 R7 R8: four errors, one out of range, busy then ready
      loc_pair0 = {16'd519, 16'd419};
      mag_pair0 = {16'h0081, 16'h005A};
      loc_pair1 = {16'd3, 16'd8};
      mag_pair1 = {16'h0033, 16'h00FF};
      ec = model(32'h0003_0200);
      run("four", 32'h0000_0800, 32'h0003_0200, 3, ec, 0, lat);
      chk(ec == 3, "R8 skip counted model", ec, 3);
      chk(lat < TMO, "R4 early exit on busy", lat, TMO);

      // R4: false complete from launch, two errors
      loc_pair0 = {16'd500, 16'd9};
      mag_pair0 = {16'h0010, 16'h0001};
      loc_pair1 = {16'd200, 16'd300};
      mag_pair1 = {16'h0077, 16'h0066};
      ec = model(32'h0001_0300);
      run("settle", 32'h0001_0300, 32'h0001_0300, 0, ec, 0, lat);
      chk(lat >= TMO + 1, "R4 waits out window", lat, TMO + 1);

      // R5: busy then clean
      run("clean", 32'h0000_0500, 32'h0000_0000, 4, 0, 0, lat);
      // R5: busy then five-or-more errors
      run("fail", 32'h0000_0F00, 32'h0000_0100, 6, 0, 1, lat);

      // R8: single error at location above 519 is skipped
      loc_pair0 = {16'd8, 16'd600};
      mag_pair0 = {16'h0044, 16'h0022};
      ec = model(32'h0000_0300);
      run("outside", 32'h0000_0400, 32'h0000_0300, 2, ec, 0, lat);
      chk(ec == 0, "R8 outside model", ec, 0);

      // R6 R7: single error at last byte (location 8 -> offset 511)
      loc_pair0 = {16'd600, 16'd8};
      mag_pair0 = {16'h0022, 16'h00C3};
      ec = model(32'h0000_0200);
      run("edge", 32'h0000_0900, 32'h0000_0200, 1, ec, 0, lat);
      chk(ec == 1, "R7 edge model", ec, 1);

      mism = 0;
      for (int i = 0; i < 512; i++) if (mem[i] != expmem[i]) mism++;
      chk(mism == 0, "R7 R8 buffer contents", mism, 0);
      chk(q_addr.size() == 0, "R6 all expected writes seen", q_addr.size(), 0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule